// File: doc/BRIEF.md
# Paged Program Address Translator

This block turns a 16-bit local address, issued either by the CPU or by the on-chip debug logic, into an 18-bit global memory address. The local space is cut into four 16 KB quarters. The quarter at 0x8000–0xBFFF is a paging window: a 4-bit page index chooses which of 16 pages of program memory appears there. The other quarters map to fixed places in global memory, so their translation never depends on a page register.

Two page registers sit on a small register bus. One serves the CPU. The other serves debug traffic. The debug register takes over only when the debug paging feature is enabled and the access comes from a debug hardware command or from firmware that debug mode is running. When debug mode is active and the CPU page register holds all-ones, the top 256 bytes of the window belong to the debug firmware and registers. Accesses there raise an overlay select in place of a paged access.

Translation is purely combinational within a cycle. A register write lands on the clock edge, so it first affects the access in the following cycle.

Top module: `page_xlate`

## Requirements
- R1: A local address in 0x8000–0xBFFF (bits 15:14 = 2'b10) translates to {page[3:0], local[13:0]} with `paged` high, where page is the selected page index (see R7).
- R2: A local address in 0xC000–0xFFFF translates to {4'hF, local[13:0]} with `paged` low, whatever both page registers hold.
- R3: A local address in 0x4000–0x7FFF translates to {4'hE, local[13:0]} with `paged` low, whatever both page registers hold.
- R4: A local address below 0x4000 translates to the local address zero-extended to 18 bits, with `paged` low.
- R5: Register bus: `reg_addr`=0 selects the 8-bit CPU page register and `reg_addr`=1 selects the 4-bit debug page register. The debug register reads back in bits 3:0, with bits 7:4 reading as zero. `reg_rdata` shows the selected register in the same cycle. A write with `reg_wr` high is stored at the rising clock edge and is first seen in the next cycle.
- R6: After reset, both page registers read 0x00.
- R7: The debug page register supplies the page index when `dbg_page_en` is high and either `dbg_hw_cmd` or `dbg_fw_exec` is high. In every other case, bits 3:0 of the CPU page register supply it.
- R8: Overlay case: `dbg_active` is high, the CPU page register equals 0xFF, and the local address lies in 0xBF00–0xBFFF. In this case `overlay_sel` is high, `paged` is low, and the global address is the local address zero-extended.
- R9: `overlay_sel` stays low in three cases: `dbg_active` is low, the CPU page register differs from 0xFF, or the address lies outside 0xBF00–0xBFFF (for example 0xBEFF or 0xC000). In those cases the access follows R1–R4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 1 | Register select: 0 CPU page, 1 debug page |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Selected register contents |
| dbg_active | input | 1 | Debug mode is active |
| dbg_page_en | input | 1 | Debug paging feature enabled |
| dbg_hw_cmd | input | 1 | Current access comes from a debug hardware command |
| dbg_fw_exec | input | 1 | CPU is executing debug firmware for a command |
| local_addr | input | 16 | Local address to translate |
| glob_addr | output | 18 | Translated global address |
| paged | output | 1 | Access went through the paging window |
| overlay_sel | output | 1 | Debug firmware/register overlay selected |

## Verification
The bench builds the block with its default parameters: 16-bit local addresses, a 4-bit page index and 8-bit registers. With these widths, every page, all four address quarters, the all-ones CPU page that arms the overlay, and the 0xBF00 and 0xBEFF edges of the overlay range are within reach. The random stimulus writes 0xFF often and steers addresses into 0xBFxx often, so overlay hits and near misses occur many times. The debug qualifier inputs are randomized independently of each other, so each combination that selects or ignores the debug page register is exercised.

// File: rtl/page_xlate.sv
module page_xlate #(
  parameter int LADDR_W = 16,
  parameter int PAGE_W  = 4,
  parameter int REG_W   = 8
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        reg_wr,
  input  logic                        reg_addr,
  input  logic [REG_W-1:0]            reg_wdata,
  output logic [REG_W-1:0]            reg_rdata,
  input  logic                        dbg_active,
  input  logic                        dbg_page_en,
  input  logic                        dbg_hw_cmd,
  input  logic                        dbg_fw_exec,
  input  logic [LADDR_W-1:0]          local_addr,
  output logic [PAGE_W+LADDR_W-3:0]   glob_addr,
  output logic                        paged,
  output logic                        overlay_sel
);
  localparam int OFS_W   = LADDR_W - 2;
  localparam int GADDR_W = PAGE_W + OFS_W;
  localparam int TAG_W   = LADDR_W - 8;
  localparam logic [PAGE_W-1:0] PG_TOP = {PAGE_W{1'b1}};
  localparam logic [PAGE_W-1:0] PG_MID = {{(PAGE_W-1){1'b1}}, 1'b0};
  localparam logic [TAG_W-1:0]  OVL_TAG = {2'b10, {(TAG_W-2){1'b1}}};

  logic [REG_W-1:0]  cpu_page;
  logic [PAGE_W-1:0] dbg_page;
  logic              use_dbg;
  logic [PAGE_W-1:0] win_page;
  logic [1:0]        quarter;
  logic [OFS_W-1:0]  offset;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cpu_page <= '0;
      dbg_page <= '0;
    end else if (reg_wr) begin
      if (reg_addr) dbg_page <= reg_wdata[PAGE_W-1:0];
      else          cpu_page <= reg_wdata;
    end
  end

  assign reg_rdata = reg_addr ? REG_W'(dbg_page) : cpu_page;

  assign use_dbg  = dbg_page_en & (dbg_hw_cmd | dbg_fw_exec);
  assign win_page = use_dbg ? dbg_page : cpu_page[PAGE_W-1:0];
  assign quarter  = local_addr[LADDR_W-1 -: 2];
  assign offset   = local_addr[OFS_W-1:0];

  assign overlay_sel = dbg_active && (&cpu_page) &&
                       (local_addr[LADDR_W-1 -: TAG_W] == OVL_TAG);

  always_comb begin
    paged     = 1'b0;
    glob_addr = GADDR_W'(local_addr);
    if (!overlay_sel) begin
      unique case (quarter)
        2'b11: glob_addr = {PG_TOP, offset};
        2'b10: begin
          glob_addr = {win_page, offset};
          paged     = 1'b1;
        end
        2'b01: glob_addr = {PG_MID, offset};
        default: glob_addr = GADDR_W'(local_addr);
      endcase
    end
  end
endmodule

module page_xlate_chk #(
  parameter int LADDR_W = 16,
  parameter int PAGE_W  = 4,
  parameter int REG_W   = 8
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      reg_wr,
  input logic                      reg_addr,
  input logic [REG_W-1:0]          reg_wdata,
  input logic [REG_W-1:0]          cpu_page,
  input logic                      dbg_active,
  input logic [LADDR_W-1:0]        local_addr,
  input logic [PAGE_W+LADDR_W-3:0] glob_addr,
  input logic                      paged,
  input logic                      overlay_sel
);
  localparam int OFS_W = LADDR_W - 2;

  assert_window_only_R1: assert property (@(posedge clk) disable iff (!rst_n)
    paged |-> local_addr[LADDR_W-1 -: 2] == 2'b10);

  assert_top_fixed_R2: assert property (@(posedge clk) disable iff (!rst_n)
    local_addr[LADDR_W-1 -: 2] == 2'b11 |->
      !paged && glob_addr[PAGE_W+OFS_W-1 -: PAGE_W] == {PAGE_W{1'b1}});

  assert_cpu_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr && !reg_addr |=> cpu_page == $past(reg_wdata));

  assert_overlay_unpaged_R8: assert property (@(posedge clk) disable iff (!rst_n)
    overlay_sel |-> !paged && glob_addr == (PAGE_W+OFS_W)'(local_addr));

  assert_overlay_gated_R9: assert property (@(posedge clk) disable iff (!rst_n)
    overlay_sel |-> dbg_active && (&cpu_page));
endmodule

bind page_xlate page_xlate_chk #(.LADDR_W(LADDR_W), .PAGE_W(PAGE_W), .REG_W(REG_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .cpu_page(cpu_page), .dbg_active(dbg_active),
  .local_addr(local_addr), .glob_addr(glob_addr), .paged(paged),
  .overlay_sel(overlay_sel));

// File: tb/page_xlate_tb.sv
module page_xlate_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0, reg_addr = 1'b0;
  logic [7:0]  reg_wdata = '0;
  logic [7:0]  reg_rdata;
  logic        dbg_active = 1'b0, dbg_page_en = 1'b0, dbg_hw_cmd = 1'b0, dbg_fw_exec = 1'b0;
  logic [15:0] local_addr = '0;
  logic [17:0] glob_addr;
  logic        paged, overlay_sel;

  int errors = 0, checks = 0;
  logic [7:0] m_cpu = '0;
  logic [3:0] m_dbg = '0;

  always #5 clk = ~clk;

  page_xlate u_dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .dbg_active(dbg_active),
    .dbg_page_en(dbg_page_en), .dbg_hw_cmd(dbg_hw_cmd), .dbg_fw_exec(dbg_fw_exec),
    .local_addr(local_addr), .glob_addr(glob_addr), .paged(paged),
    .overlay_sel(overlay_sel));

  function automatic logic exp_ovl();
    return dbg_active && m_cpu == 8'hFF && local_addr[15:8] == 8'hBF;
  endfunction

  function automatic logic [3:0] exp_page();
    return (dbg_page_en && (dbg_hw_cmd || dbg_fw_exec)) ? m_dbg : m_cpu[3:0];
  endfunction

  function automatic logic [17:0] exp_glob();
    if (exp_ovl()) return {2'b00, local_addr};
    case (local_addr[15:14])
      2'b11:   return {4'hF, local_addr[13:0]};
      2'b10:   return {exp_page(), local_addr[13:0]};
      2'b01:   return {4'hE, local_addr[13:0]};
      default: return {2'b00, local_addr};
    endcase
  endfunction

  function automatic string req_of();
    if (exp_ovl()) return "R8";
    case (local_addr[15:14])
      2'b11:   return "R2";
      2'b10:   return (dbg_page_en && (dbg_hw_cmd || dbg_fw_exec)) ? "R7/R1" : "R1";
      2'b01:   return "R3";
      default: return "R4";
    endcase
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s addr=%h actual=%h expected=%h", req, local_addr, act, exp);
    end
  endtask

  task automatic check_all();
    chk({req_of(), " glob"}, 32'(glob_addr), 32'(exp_glob()));
    chk({req_of(), " paged"}, 32'(paged),
        32'(!exp_ovl() && local_addr[15:14] == 2'b10));
    chk(exp_ovl() ? "R8 ovl" : "R9 ovl", 32'(overlay_sel), 32'(exp_ovl()));
    chk("R5 rdata", 32'(reg_rdata), 32'(reg_addr ? {4'h0, m_dbg} : m_cpu));
  endtask

  task automatic cycle();
    #1 check_all();
    @(posedge clk);
    if (reg_wr) begin
      if (reg_addr) m_dbg = reg_wdata[3:0];
      else          m_cpu = reg_wdata;
    end
    @(negedge clk);
  endtask

  task automatic wr(input logic a, input logic [7:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    cycle();
    reg_wr = 1'b0;
  endtask

  task automatic at(input logic [15:0] a);
    local_addr = a;
    cycle();
  endtask

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog expired");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R6: reset values of both registers
    reg_addr = 1'b0; #1 chk("R6 cpu reset", 32'(reg_rdata), 32'h00);
    reg_addr = 1'b1; #1 chk("R6 dbg reset", 32'(reg_rdata), 32'h00);
    @(negedge clk);
    // R1 window, R5 write effective next cycle
    wr(1'b0, 8'h05);
    at(16'h8000); at(16'hBFFF);
    at(16'h7FFF); at(16'h4000); at(16'h3FFF); at(16'hC000); at(16'hFFFF);
    // R5 debug register upper bits read zero
    wr(1'b1, 8'hAB);
    reg_addr = 1'b1; at(16'h0000);
    // R7 debug page selected by hardware command or firmware execution
    dbg_page_en = 1'b1; dbg_hw_cmd = 1'b1; at(16'h9234);
    dbg_hw_cmd = 1'b0; dbg_fw_exec = 1'b1; at(16'h9234);
    dbg_page_en = 1'b0; at(16'h9234);
    dbg_fw_exec = 1'b0;
    // R8/R9 overlay corners
    wr(1'b0, 8'hFF);
    dbg_active = 1'b1;
    at(16'hBF00); at(16'hBFFF); at(16'hBEFF); at(16'hC000);
    dbg_active = 1'b0; at(16'hBF10);
    dbg_active = 1'b1; wr(1'b0, 8'hFE); at(16'hBF10);
    // random mix
    for (int i = 0; i < 3000; i++) begin
      reg_wr      = ($urandom_range(0, 3) == 0);
      reg_addr    = $urandom_range(0, 1);
      reg_wdata   = ($urandom_range(0, 2) == 0) ? 8'hFF : 8'($urandom());
      dbg_active  = $urandom_range(0, 1);
      dbg_page_en = $urandom_range(0, 1);
      dbg_hw_cmd  = $urandom_range(0, 1);
      dbg_fw_exec = $urandom_range(0, 1);
      local_addr  = ($urandom_range(0, 2) == 0) ? {8'hBF, 8'($urandom())} : 16'($urandom());
      cycle();
    end
    reg_wr = 1'b0;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule